// File: doc/BRIEF.md
# Partial-reconfiguration freeze bridge controller

This block sits between one reconfigurable region of an FPGA and the rest of the chip. While the region is being reprogrammed it holds the region isolated: new transactions from the region are refused, and a freeze output tells the surrounding logic to ignore the region's handshakes. A host drives it through four 32-bit words. It can ask for a freeze, ask for a reset of the region while frozen, and ask for an unfreeze. It then polls the status word for completion.

A freeze does not complete at once. The block first stops granting new region transactions. It then waits for an internal outstanding-transaction counter to drain to zero, and only then raises freeze and reports completion. An unfreeze releases the region reset before it drops freeze. Requests that break the protocol are refused and leave a sticky flag that the host clears by writing 1. A constant version word lets software confirm the register layout.

Top module: `frz_bridge_ctrl`

## Requirements
- R1: After reset the status word reads 2 (bit 1 "open done" set, bit 0 "frozen done" clear), the control word and the illegal word read 0, and freeze_o, region_rst_o and region_gnt_o are low.
- R2: Word index is reg_addr_i[3:2]. Byte offset 0 is status, 4 is control (bits 2:0), 8 is the illegal flag (bit 0) and 12 is the version, which always reads 2. All other bits read 0.
- R3: region_gnt_o equals region_req_i only while the bridge is open and the counter is below its maximum. It is 0 while draining, frozen or releasing.
- R4: Writing control bit 0 while open starts a drain. freeze_o rises and the status becomes 1 only after the outstanding count has reached zero. With nothing outstanding, freeze_o is high after the second rising edge that follows the write edge.
- R5: While frozen, region_rst_o follows control bit 1 from the edge that writes it. In any other state region_rst_o is 0.
- R6: A control write with bit 1 set while not frozen, or with bits 0 and 2 both set, sets the illegal flag. The write is discarded, so control keeps its old value, and the state does not change.
- R7: The illegal flag is sticky. Writing a word with bit 0 set to offset 8 clears it, and writing bit 0 clear leaves it set.
- R8: Writing control bit 2 while frozen causes a release. After the next edge region_rst_o is 0 while freeze_o is still 1. One edge later freeze_o is 0 and the status reads 2.
- R9: A freeze bit written while frozen, or an unfreeze bit written while open, is accepted into control but changes no state and raises no flag.
- R10: The outstanding counter rises by one per grant and falls by one per region_done_i pulse. A done pulse with nothing outstanding is ignored. At the maximum of 2**CNT_W-1 no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| region_req_i | input | 1 | Region asks to start a transaction |
| region_gnt_o | output | 1 | Transaction accepted this cycle |
| region_done_i | input | 1 | One outstanding transaction has completed |
| freeze_o | output | 1 | Region isolated; its handshakes must be ignored |
| region_rst_o | output | 1 | Reset to the isolated region |

## Verification
The hardest case to reach is a freeze request that arrives while transactions are still outstanding. That is the only way to hold the bridge in its drain phase, and there freeze must stay low even though grants are already blocked. The bench accepts several grants, writes the freeze request, and holds the region's request high to confirm that grants stay blocked. It then retires the transactions one by one and checks that freeze rises exactly one edge after the count reaches zero. A second hard case is a done pulse with nothing outstanding, which can only be seen later. The bench sends one while frozen and then fills the counter to prove that exactly the maximum number of grants is still given.

// File: rtl/frz_pkg.sv
package frz_pkg;
  typedef enum logic [1:0] {
    ST_OPEN    = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_HELD    = 2'd2,
    ST_RELEASE = 2'd3
  } frz_state_e;

  localparam int unsigned WIDX_STATUS  = 0;
  localparam int unsigned WIDX_CTRL    = 1;
  localparam int unsigned WIDX_ILLEGAL = 2;
  localparam int unsigned WIDX_VERSION = 3;

  localparam int unsigned CB_FREEZE   = 0;
  localparam int unsigned CB_RESET    = 1;
  localparam int unsigned CB_UNFREEZE = 2;
  localparam int unsigned CTRL_W      = 3;

  localparam logic [31:0] VERSION_VAL = 32'd2;
endpackage

// File: rtl/frz_txn_count.sv
module frz_txn_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic req_i,
  input  logic done_i,
  output logic gnt_o,
  output logic idle_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign gnt_o  = req_i && open_i && (cnt_q != CNT_MAX);
  assign dec    = done_i && (cnt_q != '0);
  assign idle_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (gnt_o && !dec) cnt_q <= cnt_q + 1'b1;
    else if (!gnt_o && dec) cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == CNT_MAX) |-> (cnt_q != '0)); // R10
  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == '0) |-> (cnt_q <= 1)); // R10
endmodule

// File: rtl/frz_seq.sv
module frz_seq
  import frz_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frz_req_i,
  input  logic rst_req_i,
  input  logic unfrz_req_i,
  input  logic idle_i,
  output logic open_o,
  output logic held_o,
  output logic freeze_o,
  output logic rst_o,
  output logic frozen_done_o,
  output logic open_done_o
);
  frz_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN:    if (frz_req_i)   state_d = ST_DRAIN;
      ST_DRAIN:   if (idle_i)      state_d = ST_HELD;
      ST_HELD:    if (unfrz_req_i) state_d = ST_RELEASE;
      ST_RELEASE:                  state_d = ST_OPEN;
      default:                     state_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OPEN;
    else         state_q <= state_d;
  end

  assign open_o        = (state_q == ST_OPEN);
  assign held_o        = (state_q == ST_HELD);
  assign freeze_o      = (state_q == ST_HELD) || (state_q == ST_RELEASE);
  assign rst_o         = held_o && rst_req_i;
  assign frozen_done_o = freeze_o;
  assign open_done_o   = (state_q == ST_OPEN) || (state_q == ST_DRAIN);

  // freeze only completes once the counter has drained
  AST_FREEZE_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(freeze_o) |-> $past(idle_i)); // R4
  AST_RST_BEFORE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(freeze_o) |-> $past(!rst_o)); // R8
endmodule

// File: rtl/frz_bridge_ctrl.sv
module frz_bridge_ctrl
  import frz_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              region_req_i,
  output logic              region_gnt_o,
  input  logic              region_done_i,
  output logic              freeze_o,
  output logic              region_rst_o
);
  localparam int unsigned WSEL_LO = 2;
  localparam int unsigned WSEL_W  = 2;

  logic [WSEL_W-1:0] wsel;
  logic [CTRL_W-1:0] ctrl_q, wr_ctrl;
  logic              ill_q;
  logic              open, held, idle, frozen_done, open_done;
  logic              wr_ctrl_en, wr_ill_en, wr_bad;
  logic              unused_bits;

  assign wsel        = reg_addr_i[WSEL_LO +: WSEL_W];
  assign wr_ctrl     = reg_wdata_i[CTRL_W-1:0];
  assign wr_ctrl_en  = reg_wr_i && (wsel == WSEL_W'(WIDX_CTRL));
  assign wr_ill_en   = reg_wr_i && (wsel == WSEL_W'(WIDX_ILLEGAL));
  assign wr_bad      = (wr_ctrl[CB_RESET] && !held) ||
                       (wr_ctrl[CB_FREEZE] && wr_ctrl[CB_UNFREEZE]);
  assign unused_bits = ^{reg_addr_i, reg_wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      if (wr_ctrl_en) begin
        if (wr_bad) ill_q  <= 1'b1;
        else        ctrl_q <= wr_ctrl;
      end
      if (wr_ill_en && reg_wdata_i[0]) ill_q <= 1'b0;
    end
  end

  frz_txn_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (open),
    .req_i  (region_req_i),
    .done_i (region_done_i),
    .gnt_o  (region_gnt_o),
    .idle_o (idle)
  );

  frz_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frz_req_i     (ctrl_q[CB_FREEZE]),
    .rst_req_i     (ctrl_q[CB_RESET]),
    .unfrz_req_i   (ctrl_q[CB_UNFREEZE]),
    .idle_i        (idle),
    .open_o        (open),
    .held_o        (held),
    .freeze_o      (freeze_o),
    .rst_o         (region_rst_o),
    .frozen_done_o (frozen_done),
    .open_done_o   (open_done)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (wsel)
      WSEL_W'(WIDX_STATUS):  reg_rdata_o[1:0] = {open_done, frozen_done};
      WSEL_W'(WIDX_CTRL):    reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      WSEL_W'(WIDX_ILLEGAL): reg_rdata_o[0] = ill_q;
      default:               reg_rdata_o = VERSION_VAL;
    endcase
  end

  AST_NO_GNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |-> !region_gnt_o); // R3
  AST_RST_ONLY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_rst_o |-> freeze_o); // R5
  AST_ILL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ill_q) && !$past(wr_ill_en && reg_wdata_i[0])) |-> ill_q); // R7
  AST_BAD_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_ctrl_en && wr_bad) |-> (ctrl_q == $past(ctrl_q))); // R6
endmodule

// File: tb/frz_bridge_ctrl_tb_top.sv
module frz_bridge_ctrl_tb_top;
  localparam int unsigned CNT_MAX = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        region_req_i = 1'b0;
  logic        region_gnt_o;
  logic        region_done_i = 1'b0;
  logic        freeze_o;
  logic        region_rst_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit frozen_now = 0;

  always #2 clk_i = ~clk_i;

  frz_bridge_ctrl #(.ADDR_W(4), .CNT_W(4)) dut_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .region_req_i, .region_gnt_o, .region_done_i, .freeze_o, .region_rst_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic go_frozen();
    wr(4'd4, 32'd0); wr(4'd4, 32'd1); idle_cycles(3); frozen_now = 1;
  endtask

  task automatic go_open();
    wr(4'd4, 32'd0); wr(4'd4, 32'd4); idle_cycles(3); wr(4'd4, 32'd0); frozen_now = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle_cycles(3);
    rst_ni = 1'b1;
    idle_cycles(1);

    // R1 reset state, R2 map
    rd(4'd0, d);  chk("R1 status", d, 32'd2);
    rd(4'd4, d);  chk("R1 ctrl", d, 32'd0);
    rd(4'd8, d);  chk("R1 illegal", d, 32'd0);
    rd(4'd12, d); chk("R2 version", d, 32'd2);
    chk("R1 freeze", freeze_o, 0);
    chk("R1 region_rst", region_rst_o, 0);
    chk("R1 gnt", region_gnt_o, 0);

    // R4 latency with nothing outstanding, R3 grant blocked while draining
    wr(4'd4, 32'd1);
    chk("R4 freeze after write edge", freeze_o, 0);
    rd(4'd0, d); chk("R4 status before done", d, 32'd2);
    @(negedge clk_i);
    region_req_i = 1'b1; #1;
    chk("R3 gnt in drain", region_gnt_o, 0);
    chk("R4 freeze after 1 edge", freeze_o, 0);
    region_req_i = 1'b0;
    @(negedge clk_i);
    chk("R4 freeze after 2 edges", freeze_o, 1);
    rd(4'd0, d); chk("R4 status frozen", d, 32'd1);
    frozen_now = 1;

    // R5 reset follows control bit 1 while frozen; R8 release order
    wr(4'd4, 32'd2);
    chk("R5 rst on", region_rst_o, 1);
    wr(4'd4, 32'd0);
    chk("R5 rst off", region_rst_o, 0);
    wr(4'd4, 32'd2);
    wr(4'd4, 32'd6);
    chk("R5 rst kept until release", region_rst_o, 1);
    @(negedge clk_i);
    chk("R8 rst dropped first", region_rst_o, 0);
    chk("R8 freeze still high", freeze_o, 1);
    @(negedge clk_i);
    chk("R8 freeze released", freeze_o, 0);
    rd(4'd0, d); chk("R8 status open", d, 32'd2);
    wr(4'd4, 32'd0);
    frozen_now = 0;

    // R7 sticky flag
    wr(4'd4, 32'd2);
    rd(4'd8, d); chk("R6 illegal set", d, 32'd1);
    wr(4'd8, 32'd0);
    rd(4'd8, d); chk("R7 write 0 keeps", d, 32'd1);
    wr(4'd8, 32'd1);
    rd(4'd8, d); chk("R7 write 1 clears", d, 32'd0);

    // near-exhaustive sweep of control values from both stable states
    for (int st = 0; st < 2; st++) begin
      for (int v = 0; v < 8; v++) begin
        logic [2:0] vv;
        bit bad, nf, exp_rst;
        string tag;
        vv = 3'(v);
        if (st == 1 && !frozen_now) go_frozen();
        if (st == 0 && frozen_now)  go_open();
        wr(4'd4, 32'd0);
        wr(4'd8, 32'd1);
        wr(4'd4, 32'(vv));
        idle_cycles(4);
        bad = (vv[1] && st == 0) || (vv[0] && vv[2]);
        if (bad) nf = (st == 1);
        else if (st == 1) nf = !vv[2];
        else nf = vv[0];
        exp_rst = nf && vv[1] && !bad;
        if (bad) tag = "R6";
        else if (nf == (st == 1)) tag = "R9";
        else if (st == 0) tag = "R4";
        else tag = "R8";
        rd(4'd8, d); chk($sformatf("%s sweep st=%0d v=%0d illegal", tag, st, v), d, 32'(bad));
        rd(4'd4, d); chk($sformatf("%s sweep st=%0d v=%0d ctrl", tag, st, v), d, bad ? 32'd0 : 32'(vv));
        rd(4'd0, d); chk($sformatf("%s sweep st=%0d v=%0d status", tag, st, v), d, nf ? 32'd1 : 32'd2);
        chk($sformatf("%s sweep st=%0d v=%0d freeze", tag, st, v), freeze_o, 32'(nf));
        chk($sformatf("R5 sweep st=%0d v=%0d rst", st, v), region_rst_o, 32'(exp_rst));
        frozen_now = nf;
      end
    end
    if (frozen_now) go_open();
    wr(4'd4, 32'd0);

    // drain with outstanding transactions (R4, R3, R10)
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      region_req_i = 1'b1; #1;
      chk("R3 gnt while open", region_gnt_o, 1);
    end
    @(negedge clk_i);
    region_req_i = 1'b0;
    wr(4'd4, 32'd1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      region_req_i = 1'b1; #1;
      chk("R4 freeze held off while outstanding", freeze_o, 0);
      chk("R3 gnt blocked while draining", region_gnt_o, 0);
      region_req_i = 1'b0;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      region_done_i = 1'b1;
    end
    @(negedge clk_i);
    region_done_i = 1'b0;
    chk("R4 freeze not yet at zero", freeze_o, 0);
    @(negedge clk_i);
    chk("R4 freeze one edge after zero", freeze_o, 1);
    frozen_now = 1;

    // R10 done at zero ignored, then fill to maximum
    @(negedge clk_i);
    region_done_i = 1'b1;
    @(negedge clk_i);
    region_done_i = 1'b0;
    go_open();
    for (int i = 0; i < CNT_MAX; i++) begin
      @(negedge clk_i);
      region_req_i = 1'b1; #1;
      chk("R10 gnt below max", region_gnt_o, 1);
    end
    @(negedge clk_i);
    #1;
    chk("R10 gnt at max", region_gnt_o, 0);
    region_req_i = 1'b0;
    @(negedge clk_i);
    region_done_i = 1'b1;
    @(negedge clk_i);
    region_done_i = 1'b0;
    region_req_i = 1'b1; #1;
    chk("R10 gnt after one done", region_gnt_o, 1);
    @(negedge clk_i);
    region_req_i = 1'b0; #1;
    chk("R10 gnt with no request", region_gnt_o, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule